// File: doc/BRIEF.md
# Masked Video Register File

This block holds the programmable words that set up a video timing generator and a display fetch path. A host reaches it over a simple bus: valid, write, byte address and 32-bit data. Each write is cut down to the bits that the target register implements. A few addresses hold no state at all. A write to one of them either fires a single-cycle command strobe or does nothing. The decoded timing fields are driven out continuously, so the timing generator can use them without any further decode.

Reads are registered. Most addresses return the stored word. The sync-status address returns the live status word from the timing generator, sampled at the read edge. A window of 256 words stores data unmasked and is used as a lookup table. The timing generator reports the start of vertical retrace on `retrace_evt`, which arms a pending frame swap. The next write of the display base address completes that swap: it emits `frame_latch` and clears the pending flag.

Top module: `vidreg_bank`

## Requirements
- R1: After reset, every stored register reads 0. The strobes, `swap_pending`, `rd_data` and all decoded field outputs are also 0.
- R2: Writes are masked per register (byte offsets):
  - control word 0x008 keeps bits 2:0;
  - display mode 0x044 is masked with 0x00FFFF7F;
  - display base 0x050 is masked with 0x00FFFFFC;
  - display size 0x05C keeps bits 29:0;
  - sync configuration 0x0D0 keeps bits 9:0;
  - line-interrupt 0x0CC, timing totals 0x0D8, horizontal border 0x0E0, vertical border 0x0E4 and vertical position 0x0F0 are each masked with 0x03FF03FF.
- R3: Identity 0x000 reads the `ID_VALUE` parameter, revision 0x004 reads `REV_VALUE`, and gun position 0x0C4 reads the `gun_word` input. Writes to these three addresses change nothing.
- R4: A write to 0x014 raises `start_pulse` only when the data is exactly 0x00000001 or 0xFFFFFFFF. The address stores nothing and reads 0.
- R5: A write to 0x144 raises `init_pulse` only when data bit 31 is 1. The address stores nothing and reads 0.
- R6: Swap pending and frame latch:
  - `retrace_evt` sets `swap_pending`;
  - a write to 0x050 while the flag is set raises `frame_latch` one cycle later and clears the flag;
  - a write to 0x050 with the flag clear raises no `frame_latch`;
  - a `retrace_evt` in the same cycle as a write that clears the flag leaves the flag set.
- R7: Word-aligned byte offsets 0x200 through 0x5FC form a 256-entry table that stores all 32 bits unmasked.
- R8: A write to an undecoded address is discarded, and a read of one returns 0. Undecoded addresses include 0x600 and misaligned offsets inside the table window.
- R9: A read of 0x10C returns the `sync_word` input as sampled at the read request edge.
- R10: `rd_data` is updated one clock after a read request and holds its value in every cycle with no read.
- R11: `start_pulse`, `init_pulse` and `frame_latch` are registered on the edge that takes the write, and each lasts one clock cycle.
- R12: Decoded field outputs:
  - `lines_m1` is totals bits 25:16 and `dots_m1` is totals bits 9:0;
  - `irq_line_a` is line-interrupt bits 25:16 and `irq_line_b` is line-interrupt bits 9:0;
  - `base_addr`, `disp_mode`, `disp_size`, `sync_cfg` and `core_reset` show their stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| sync_word | input | 32 | Live sync status from the timing generator |
| gun_word | input | 32 | Live gun position word |
| retrace_evt | input | 1 | Vertical retrace start event |
| start_pulse | output | 1 | Render start strobe |
| init_pulse | output | 1 | Tile engine init strobe |
| frame_latch | output | 1 | Frame swap completion strobe |
| swap_pending | output | 1 | Retrace seen, swap not yet completed |
| base_addr | output | 32 | Stored display base |
| disp_mode | output | 32 | Stored display mode |
| disp_size | output | 32 | Stored display size |
| sync_cfg | output | 10 | Stored sync configuration |
| core_reset | output | 3 | Stored control bits |
| lines_m1 | output | 10 | Lines per frame minus one |
| dots_m1 | output | 10 | Dots per line minus one |
| irq_line_a | output | 10 | First interrupt line |
| irq_line_b | output | 10 | Second interrupt line |

## Verification
Every result is due exactly one clock after the edge that takes the request. Read data, the three strobes, the pending flag and the decoded fields all follow this rule. The bench drives requests on the falling edge. It samples the strobes and the fields on the next falling edge, once the taking edge has passed. The bench also records each read at the rising edge that takes it, and its monitor compares `rd_data` on the falling edge that follows. One further idle cycle confirms that the strobes have dropped and that the read data has held.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

   localparam int unsigned N_SLOT = 10;

   // Stored slots come first, so a selector below N_SLOT is also a slot index.
   typedef enum logic [4:0] {
      SL_CORERST  = 5'd0,
      SL_MODE     = 5'd1,
      SL_BASE     = 5'd2,
      SL_SIZE     = 5'd3,
      SL_VIRQ     = 5'd4,
      SL_SYNCCFG  = 5'd5,
      SL_TOTAL    = 5'd6,
      SL_HBORDER  = 5'd7,
      SL_VBORDER  = 5'd8,
      SL_VPOS     = 5'd9,
      SL_IDENT    = 5'd10,
      SL_REV      = 5'd11,
      SL_GUN      = 5'd12,
      SL_GO       = 5'd13,
      SL_TAINIT   = 5'd14,
      SL_SYNCSTAT = 5'd15,
      SL_TABLE    = 5'd16,
      SL_NONE     = 5'd17
   } sel_e;

   // Byte offsets of the register map.
   localparam logic [15:0] OFS_IDENT    = 16'h000;
   localparam logic [15:0] OFS_REV      = 16'h004;
   localparam logic [15:0] OFS_CORERST  = 16'h008;
   localparam logic [15:0] OFS_GO       = 16'h014;
   localparam logic [15:0] OFS_MODE     = 16'h044;
   localparam logic [15:0] OFS_BASE     = 16'h050;
   localparam logic [15:0] OFS_SIZE     = 16'h05C;
   localparam logic [15:0] OFS_GUN      = 16'h0C4;
   localparam logic [15:0] OFS_VIRQ     = 16'h0CC;
   localparam logic [15:0] OFS_SYNCCFG  = 16'h0D0;
   localparam logic [15:0] OFS_TOTAL    = 16'h0D8;
   localparam logic [15:0] OFS_HBORDER  = 16'h0E0;
   localparam logic [15:0] OFS_VBORDER  = 16'h0E4;
   localparam logic [15:0] OFS_VPOS     = 16'h0F0;
   localparam logic [15:0] OFS_SYNCSTAT = 16'h10C;
   localparam logic [15:0] OFS_TAINIT   = 16'h144;

   localparam logic [31:0] GO_KEY_LO = 32'h0000_0001;
   localparam logic [31:0] GO_KEY_HI = 32'hFFFF_FFFF;

   // Implemented bits of each stored slot.
   function automatic logic [31:0] slot_mask(input int unsigned s);
      case (s)
         0:       slot_mask = 32'h0000_0007;
         1:       slot_mask = 32'h00FF_FF7F;
         2:       slot_mask = 32'h00FF_FFFC;
         3:       slot_mask = 32'h3FFF_FFFF;
         5:       slot_mask = 32'h0000_03FF;
         4, 6, 7, 8, 9:
                  slot_mask = 32'h03FF_03FF;
         default: slot_mask = 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/vidreg_decode.sv
module vidreg_decode
   import vidreg_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned TBL_EN = 1,
   parameter int unsigned TBL_LO = 32'h200,
   parameter int unsigned TBL_HI = 32'h600,
   parameter int unsigned IDX_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output logic [IDX_W-1:0]  tidx
);

   logic [ADDR_W-1:0] tbl_off;

   always_comb begin
      tbl_off = addr - ADDR_W'(TBL_LO);
      tidx    = '0;
      case (addr)
         ADDR_W'(OFS_IDENT):    sel = SL_IDENT;
         ADDR_W'(OFS_REV):      sel = SL_REV;
         ADDR_W'(OFS_CORERST):  sel = SL_CORERST;
         ADDR_W'(OFS_GO):       sel = SL_GO;
         ADDR_W'(OFS_MODE):     sel = SL_MODE;
         ADDR_W'(OFS_BASE):     sel = SL_BASE;
         ADDR_W'(OFS_SIZE):     sel = SL_SIZE;
         ADDR_W'(OFS_GUN):      sel = SL_GUN;
         ADDR_W'(OFS_VIRQ):     sel = SL_VIRQ;
         ADDR_W'(OFS_SYNCCFG):  sel = SL_SYNCCFG;
         ADDR_W'(OFS_TOTAL):    sel = SL_TOTAL;
         ADDR_W'(OFS_HBORDER):  sel = SL_HBORDER;
         ADDR_W'(OFS_VBORDER):  sel = SL_VBORDER;
         ADDR_W'(OFS_VPOS):     sel = SL_VPOS;
         ADDR_W'(OFS_SYNCSTAT): sel = SL_SYNCSTAT;
         ADDR_W'(OFS_TAINIT):   sel = SL_TAINIT;
         default:               sel = SL_NONE;
      endcase
      if (TBL_EN != 0 && addr >= ADDR_W'(TBL_LO) && addr < ADDR_W'(TBL_HI)
          && addr[1:0] == 2'b00) begin
         sel  = SL_TABLE;
         tidx = IDX_W'(tbl_off >> 2);
      end
   end

endmodule

// File: rtl/vidreg_table.sv
module vidreg_table #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata
);

   logic [31:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/vidreg_cmd.sv
module vidreg_cmd
   import vidreg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go_wr,
   input  logic        init_wr,
   input  logic        base_wr,
   input  logic [31:0] wdata,
   input  logic        retrace_evt,
   output logic        start_pulse,
   output logic        init_pulse,
   output logic        frame_latch,
   output logic        pending
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         init_pulse  <= 1'b0;
         frame_latch <= 1'b0;
         pending     <= 1'b0;
      end else begin
         start_pulse <= go_wr && (wdata == GO_KEY_LO || wdata == GO_KEY_HI);
         init_pulse  <= init_wr && wdata[31];
         frame_latch <= base_wr && pending;
         pending     <= (pending && !base_wr) || retrace_evt;
      end
   end

endmodule

// File: rtl/vidreg_bank.sv
module vidreg_bank
   import vidreg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned TBL_EN    = 1,
   parameter int unsigned TBL_LO    = 32'h200,
   parameter int unsigned TBL_HI    = 32'h600,
   parameter logic [31:0] ID_VALUE  = 32'h0051_0C07,
   parameter logic [31:0] REV_VALUE = 32'h0000_0012
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       rd_data,
   input  logic [31:0]       sync_word,
   input  logic [31:0]       gun_word,
   input  logic              retrace_evt,
   output logic              start_pulse,
   output logic              init_pulse,
   output logic              frame_latch,
   output logic              swap_pending,
   output logic [31:0]       base_addr,
   output logic [31:0]       disp_mode,
   output logic [31:0]       disp_size,
   output logic [9:0]        sync_cfg,
   output logic [2:0]        core_reset,
   output logic [9:0]        lines_m1,
   output logic [9:0]        dots_m1,
   output logic [9:0]        irq_line_a,
   output logic [9:0]        irq_line_b
);

   localparam int unsigned TBL_DEPTH = (TBL_HI - TBL_LO) / 4;
   localparam int unsigned IDX_W     = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("vidreg_bank: ADDR_W must lie in 9..16");
   end
   if (TBL_EN != 0 && (TBL_HI <= TBL_LO || (TBL_HI - TBL_LO) % 4 != 0
                       || TBL_HI > (32'd1 << ADDR_W))) begin : g_bad_tbl
      $error("vidreg_bank: table window malformed");
   end

   sel_e             sel;
   logic [IDX_W-1:0] tidx;
   logic             wr, rd;
   logic [31:0]      tbl_rd;
   logic [31:0]      rd_mux;
   logic [31:0]      slot_q [N_SLOT];

   assign wr = bus_valid && bus_write;
   assign rd = bus_valid && !bus_write;

   vidreg_decode #(
      .ADDR_W(ADDR_W), .TBL_EN(TBL_EN), .TBL_LO(TBL_LO),
      .TBL_HI(TBL_HI), .IDX_W(IDX_W)
   ) u_dec (
      .addr(bus_addr), .sel(sel), .tidx(tidx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_SLOT; i++) slot_q[i] <= '0;
      end else begin
         for (int i = 0; i < N_SLOT; i++) begin
            if (wr && sel == sel_e'(5'(i)))
               slot_q[i] <= bus_wdata & slot_mask(i);
         end
      end
   end

   if (TBL_EN != 0) begin : g_tbl
      vidreg_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_tbl (
         .clk(clk), .we(wr && sel == SL_TABLE), .idx(tidx),
         .wdata(bus_wdata), .rdata(tbl_rd)
      );
   end else begin : g_no_tbl
      assign tbl_rd = '0;
   end

   always_comb begin
      case (sel)
         SL_IDENT:    rd_mux = ID_VALUE;
         SL_REV:      rd_mux = REV_VALUE;
         SL_GUN:      rd_mux = gun_word;
         SL_SYNCSTAT: rd_mux = sync_word;
         SL_TABLE:    rd_mux = tbl_rd;
         SL_GO, SL_TAINIT, SL_NONE:
                      rd_mux = '0;
         default:     rd_mux = slot_q[sel[3:0]];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rd_data <= '0;
      else if (rd) rd_data <= rd_mux;
   end

   vidreg_cmd u_cmd (
      .clk(clk), .rst_n(rst_n),
      .go_wr(wr && sel == SL_GO),
      .init_wr(wr && sel == SL_TAINIT),
      .base_wr(wr && sel == SL_BASE),
      .wdata(bus_wdata), .retrace_evt(retrace_evt),
      .start_pulse(start_pulse), .init_pulse(init_pulse),
      .frame_latch(frame_latch), .pending(swap_pending)
   );

   assign core_reset = slot_q[SL_CORERST][2:0];
   assign disp_mode  = slot_q[SL_MODE];
   assign base_addr  = slot_q[SL_BASE];
   assign disp_size  = slot_q[SL_SIZE];
   assign sync_cfg   = slot_q[SL_SYNCCFG][9:0];
   assign lines_m1   = slot_q[SL_TOTAL][25:16];
   assign dots_m1    = slot_q[SL_TOTAL][9:0];
   assign irq_line_a = slot_q[SL_VIRQ][25:16];
   assign irq_line_b = slot_q[SL_VIRQ][9:0];

endmodule

// File: rtl/vidreg_bank_chk.sv
module vidreg_bank_chk
   import vidreg_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       rd_data,
   input logic [31:0]       sync_word,
   input logic              retrace_evt,
   input logic              start_pulse,
   input logic              init_pulse,
   input logic              frame_latch,
   input logic              swap_pending,
   input logic [31:0]       base_addr
);

   logic go_w, init_w, base_w, sync_r, any_r;
   assign go_w   = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_GO);
   assign init_w = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_TAINIT);
   assign base_w = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_BASE);
   assign any_r  = bus_valid && !bus_write;
   assign sync_r = any_r && bus_addr == ADDR_W'(OFS_SYNCSTAT);

   p_go_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(go_w && (bus_wdata == GO_KEY_LO || bus_wdata == GO_KEY_HI)));

   p_init_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      init_pulse |-> $past(init_w && bus_wdata[31]));

   p_latch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_latch |-> ($past(swap_pending) && $past(base_w)));

   p_latch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_latch |-> (swap_pending == $past(retrace_evt)));

   p_base_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(base_w) |-> (base_addr == ($past(bus_wdata) & 32'h00FF_FFFC)));

   p_base_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(base_w) |-> $stable(base_addr));

   p_sync_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_r) |-> (rd_data == $past(sync_word)));

   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(any_r) |-> $stable(rd_data));

endmodule

bind vidreg_bank vidreg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
   .sync_word(sync_word), .retrace_evt(retrace_evt),
   .start_pulse(start_pulse), .init_pulse(init_pulse),
   .frame_latch(frame_latch), .swap_pending(swap_pending),
   .base_addr(base_addr)
);

// File: tb/sim_vidreg_bank.sv
module sim_vidreg_bank;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] TB_ID      = 32'hA5A5_0001;
   localparam logic [31:0] TB_REV     = 32'h0000_0042;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data;
   logic [31:0] sync_word = '0, gun_word = '0;
   logic        retrace_evt = 1'b0;
   logic        start_pulse, init_pulse, frame_latch, swap_pending;
   logic [31:0] base_addr, disp_mode, disp_size;
   logic [9:0]  sync_cfg, lines_m1, dots_m1, irq_line_a, irq_line_b;
   logic [2:0]  core_reset;

   int          n_total = 0, n_fail = 0, cyc = 0;
   logic        rd_seen = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vidreg_bank #(.ID_VALUE(TB_ID), .REV_VALUE(TB_REV)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
      .sync_word(sync_word), .gun_word(gun_word), .retrace_evt(retrace_evt),
      .start_pulse(start_pulse), .init_pulse(init_pulse),
      .frame_latch(frame_latch), .swap_pending(swap_pending),
      .base_addr(base_addr), .disp_mode(disp_mode), .disp_size(disp_size),
      .sync_cfg(sync_cfg), .core_reset(core_reset), .lines_m1(lines_m1),
      .dots_m1(dots_m1), .irq_line_a(irq_line_a), .irq_line_b(irq_line_b)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   // monitor: a read taken at a rising edge is compared at the following falling edge
   always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) chk("R10 unexpected read", 32'h1, 32'h0);
         else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         n_total++; n_fail++;
         $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, 20000);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 start_pulse", {31'b0, start_pulse}, 32'h0);
      chk("R1 swap_pending", {31'b0, swap_pending}, 32'h0);
      chk("R1 base_addr", base_addr, 32'h0);
      chk("R1 lines_m1", {22'b0, lines_m1}, 32'h0);
      chk("R1 rd_data", rd_data, 32'h0);
      rd(12'h044, 32'h0, "R1 mode after reset");

      // R2 masks
      wr(12'h008, 32'hFFFF_FFFF); chk("R2 core_reset", {29'b0, core_reset}, 32'h7);
      rd(12'h008, 32'h0000_0007, "R2 control mask");
      wr(12'h044, 32'hFFFF_FFFF); rd(12'h044, 32'h00FF_FF7F, "R2 mode mask");
      wr(12'h050, 32'hFFFF_FFFF); rd(12'h050, 32'h00FF_FFFC, "R2 base mask");
      wr(12'h05C, 32'hFFFF_FFFF); rd(12'h05C, 32'h3FFF_FFFF, "R2 size mask");
      wr(12'h0D0, 32'hFFFF_FFFF); rd(12'h0D0, 32'h0000_03FF, "R2 sync cfg mask");
      wr(12'h0CC, 32'hFFFF_FFFF); rd(12'h0CC, 32'h03FF_03FF, "R2 line irq mask");
      wr(12'h0D8, 32'hFFFF_FFFF); rd(12'h0D8, 32'h03FF_03FF, "R2 totals mask");
      wr(12'h0E0, 32'hFFFF_FFFF); rd(12'h0E0, 32'h03FF_03FF, "R2 hborder mask");
      wr(12'h0E4, 32'hFFFF_FFFF); rd(12'h0E4, 32'h03FF_03FF, "R2 vborder mask");
      wr(12'h0F0, 32'hFFFF_FFFF); rd(12'h0F0, 32'h03FF_03FF, "R2 vpos mask");

      // R12 decoded fields
      wr(12'h0D8, 32'hF20C_F35A);
      chk("R12 lines_m1", {22'b0, lines_m1}, 32'h20C);
      chk("R12 dots_m1", {22'b0, dots_m1}, 32'h35A);
      wr(12'h0CC, 32'h0015_0100);
      chk("R12 irq_line_a", {22'b0, irq_line_a}, 32'h015);
      chk("R12 irq_line_b", {22'b0, irq_line_b}, 32'h100);
      wr(12'h044, 32'h0012_34C5);
      chk("R12 disp_mode", disp_mode, 32'h0012_3445);
      chk("R12 sync_cfg", {22'b0, sync_cfg}, 32'h3FF);

      // R3 read-only registers
      wr(12'h000, 32'h1234_5678); rd(12'h000, TB_ID, "R3 ident");
      wr(12'h004, 32'h0); rd(12'h004, TB_REV, "R3 revision");
      gun_word = 32'h0123_0456;
      wr(12'h0C4, 32'hFFFF_FFFF); rd(12'h0C4, 32'h0123_0456, "R3 gun");

      // R4 start key, R11 width
      wr(12'h014, 32'h0000_0001);
      chk("R4 start on 1", {31'b0, start_pulse}, 32'h1);
      @(negedge clk); chk("R11 start one cycle", {31'b0, start_pulse}, 32'h0);
      wr(12'h014, 32'hFFFF_FFFF); chk("R4 start on all ones", {31'b0, start_pulse}, 32'h1);
      wr(12'h014, 32'h0000_0002); chk("R4 no start on 2", {31'b0, start_pulse}, 32'h0);
      wr(12'h014, 32'hFFFF_FFFE); chk("R4 no start near key", {31'b0, start_pulse}, 32'h0);
      rd(12'h014, 32'h0, "R4 start reads zero");

      // R5 init
      wr(12'h144, 32'h8000_0000); chk("R5 init bit31", {31'b0, init_pulse}, 32'h1);
      @(negedge clk); chk("R11 init one cycle", {31'b0, init_pulse}, 32'h0);
      wr(12'h144, 32'h7FFF_FFFF); chk("R5 no init", {31'b0, init_pulse}, 32'h0);
      rd(12'h144, 32'h0, "R5 init reads zero");

      // R6 swap
      wr(12'h050, 32'h0000_1000); chk("R6 no latch idle", {31'b0, frame_latch}, 32'h0);
      @(negedge clk); retrace_evt = 1'b1;
      @(negedge clk); retrace_evt = 1'b0;
      chk("R6 pending set", {31'b0, swap_pending}, 32'h1);
      wr(12'h050, 32'h0000_2000);
      chk("R6 latch", {31'b0, frame_latch}, 32'h1);
      chk("R6 pending cleared", {31'b0, swap_pending}, 32'h0);
      @(negedge clk); chk("R11 latch one cycle", {31'b0, frame_latch}, 32'h0);
      @(negedge clk); retrace_evt = 1'b1;
      @(negedge clk); retrace_evt = 1'b1;
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h050; bus_wdata = 32'h3000;
      @(negedge clk); retrace_evt = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
      chk("R6 latch with event", {31'b0, frame_latch}, 32'h1);
      chk("R6 event keeps pending", {31'b0, swap_pending}, 32'h1);

      // R7 table
      wr(12'h200, 32'hDEAD_BEEF); wr(12'h5FC, 32'hFFFF_FFFF); wr(12'h3F8, 32'h8000_0001);
      rd(12'h200, 32'hDEAD_BEEF, "R7 table first");
      rd(12'h5FC, 32'hFFFF_FFFF, "R7 table last");
      rd(12'h3F8, 32'h8000_0001, "R7 table middle");

      // R8 undecoded
      wr(12'h201, 32'h1111_1111); rd(12'h200, 32'hDEAD_BEEF, "R8 misaligned write ignored");
      rd(12'h201, 32'h0, "R8 misaligned read");
      wr(12'h600, 32'h2222_2222); rd(12'h600, 32'h0, "R8 past table");
      wr(12'h020, 32'h3333_3333); rd(12'h020, 32'h0, "R8 hole");

      // R9 live status, R10 hold
      sync_word = 32'h0000_1ABC;
      rd(12'h10C, 32'h0000_1ABC, "R9 sync live");
      sync_word = 32'h0000_2DEF;
      @(negedge clk); chk("R10 rd hold", rd_data, 32'h0000_1ABC);
      rd(12'h10C, 32'h0000_2DEF, "R9 sync follows");

      repeat (3) @(negedge clk);
      chk("R10 queue drained", exp_q.size(), 32'h0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule